// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio arriving on a three-wire serial link (bit clock, word clock, serial data) and turns it into parallel 24-bit left and right samples, each announced by a one-cycle strobe. All three serial lines are asynchronous to the block's own system clock. They pass through two-flop synchronizers, and a rising bit clock is detected as an edge inside the system clock domain.

A single shift engine serves four framings, selected by a 2-bit format input. A second 2-bit input sets the word length used in right-justified framing. The serial words are two's complement and sent MSB first. Within a frame the left word always precedes the right word. After reset, and after any change of either control input, the engine discards everything until the next framing edge, so a partial word is never presented.

Top module: `serial_audio_rx`

## Requirements
- R1: While and after reset, both sample outputs are zero and neither strobe pulses until a complete word has been received.
- R2: Format 01 (left-justified): word clock high is the left channel and low is the right channel. The MSB is in the first bit slot sampled after a word-clock change. A channel word is presented when the word clock next changes.
- R3: Format 00 (I2S): word clock low is the left channel and high is the right channel. The first bit slot after a word-clock change is skipped and the MSB occupies the second. A channel word is presented when the word clock next changes.
- R4: Format 10 (right-justified, 32 bit slots per channel): the word length is 24 for code 00, 20 for code 01, 16 for code 10 and 24 for code 11. Data occupies the last bits of the channel slot, starting 8, 12 or 16 slots after the word-clock change. The word is sign-extended to 24 bits.
- R5: Format 11 (frame sync): a rising word clock marks frame start and identifies no channel. The left word fills the 24 slots that follow that slot and the right word fills the next 24. Each word is presented as soon as its last slot is sampled.
- R6: In formats 00, 01 and 11, a word shorter than 24 bits is placed at the top of the output and its low bits are zero.
- R7: In formats 00 and 01, bits after the 24th of a channel are discarded without any effect on the output.
- R8: Each strobe is high for exactly one system clock. Left and right never pulse together. A strobe appears 4 system clocks after the bit-clock rise that completes or closes the word: 2 synchronizer stages, 1 edge register, 1 output register.
- R9: A change of format or word length clears the engine. No strobe occurs in the cycle after the change, and none occurs for any word whose framing edge came before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified, 11 frame sync |
| wlen | input | 2 | Right-justified word length: 00 24, 01 20, 10 16, 11 24 bits |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Serial word clock, asynchronous |
| sd_in | input | 1 | Serial data, asynchronous |
| left_data | output | 24 | Last left-channel sample |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right-channel sample |
| right_valid | output | 1 | One-cycle strobe for a new right sample |

## Verification
A strobe is due 4 system clocks after the bit-clock rise that ends its word. In the edge-framed formats that rise is the one where the opposite channel's word clock is first seen; in frame-sync format it is the last data slot. The bench marks the system-clock count of that rise. A monitor running on the falling clock edge logs every strobe, with its data and cycle, into buffers. Each check compares a logged cycle with its mark plus 4, and compares the logged words with values computed from the vector table, so no check depends on where inside a bit period it is taken.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_FS  = 2'b11
  } fmt_e;

  // Bits removed from the full word for each right-justified length code.
  function automatic int wlen_trim(input logic [1:0] code);
    case (code)
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             rise0
);

  logic [WIDTH-1:0] stg [STAGES];
  logic             prev0;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev0 <= 1'b0;
    else     prev0 <= stg[STAGES-1][0];
  end

  assign dout  = stg[STAGES-1];
  assign rise0 = stg[STAGES-1][0] & ~prev0;

endmodule

// File: rtl/sar_framer.sv
module sar_framer import sar_pkg::*; #(
  parameter int WORD_W     = 24,
  parameter int HALF_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              ws,
  input  logic              sd,
  input  fmt_e              fmt,
  input  logic [1:0]        wlen,
  input  logic              fmt_change,
  output logic              done,
  output logic              done_left,
  output logic [WORD_W-1:0] word
);

  localparam int CNT_W = $clog2(2 * HALF_SLOTS + 1);
  localparam logic [CNT_W-1:0] SLOT_MAX = '1;
  localparam logic [CNT_W-1:0] FS_LEFT_END  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] FS_RIGHT_BEG = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] FS_RIGHT_END = CNT_W'(2 * WORD_W);

  logic              ws_q, armed, ch_left;
  logic [CNT_W-1:0]  slot, s_now;
  logic [WORD_W-1:0] acc, acc_base, acc_next;
  logic [WORD_W-1:0] sh, sh_base, sh_next, ext;
  logic              trans, new_left, left_now, fs_second, fs_end;
  int                rj_len, rj_off, pos;

  always_comb begin
    trans     = (fmt == FMT_FS) ? (ws & ~ws_q) : (ws ^ ws_q);
    s_now     = trans ? '0 : slot;
    rj_len    = WORD_W - wlen_trim(wlen);
    rj_off    = HALF_SLOTS - rj_len;
    fs_second = (fmt == FMT_FS) && (s_now > FS_LEFT_END);
    fs_end    = (fmt == FMT_FS) && (s_now == FS_LEFT_END || s_now == FS_RIGHT_END);

    case (fmt)
      FMT_I2S: new_left = ~ws;
      FMT_FS:  new_left = 1'b1;
      default: new_left = ws;
    endcase
    if (fmt == FMT_FS) left_now = ~fs_second;
    else               left_now = trans ? new_left : ch_left;

    // bit position inside the current word, MSB = 0
    case (fmt)
      FMT_LJ:  pos = int'(s_now);
      FMT_I2S: pos = int'(s_now) - 1;
      FMT_FS:  pos = fs_second ? int'(s_now) - WORD_W - 1 : int'(s_now) - 1;
      default: pos = -1;
    endcase

    acc_base = (trans || (fmt == FMT_FS && s_now == FS_RIGHT_BEG)) ? '0 : acc;
    acc_next = acc_base;
    for (int i = 0; i < WORD_W; i++)
      if (pos == WORD_W - 1 - i) acc_next[i] = sd;

    sh_base = trans ? '0 : sh;
    sh_next = (fmt == FMT_RJ && int'(s_now) >= rj_off) ?
              {sh_base[WORD_W-2:0], sd} : sh_base;

    for (int i = 0; i < WORD_W; i++)
      ext[i] = (i < rj_len) ? sh[i] : sh[rj_len-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q      <= 1'b0;
      armed     <= 1'b0;
      ch_left   <= 1'b1;
      slot      <= '0;
      acc       <= '0;
      sh        <= '0;
      done      <= 1'b0;
      done_left <= 1'b0;
      word      <= '0;
    end else begin
      done <= 1'b0;
      if (bit_tick) begin
        ws_q    <= ws;
        slot    <= trans ? CNT_W'(1) : ((slot == SLOT_MAX) ? slot : slot + 1'b1);
        ch_left <= left_now;
        acc     <= (armed || trans) ? acc_next : '0;
        sh      <= (armed || trans) ? sh_next  : '0;
        if (trans) armed <= 1'b1;
        if (armed && trans && fmt != FMT_FS) begin
          done      <= 1'b1;
          done_left <= ch_left;
          word      <= (fmt == FMT_RJ) ? ext : acc;
        end
        if (armed && fs_end) begin
          done      <= 1'b1;
          done_left <= left_now;
          word      <= acc_next;
        end
      end
      if (fmt_change) begin
        armed <= 1'b0;
        done  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sar_steer.sv
module sar_steer #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              done_left,
  input  logic              hold,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] left_data,
  output logic              left_valid,
  output logic [WORD_W-1:0] right_data,
  output logic              right_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_data   <= '0;
      right_data  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
    end else begin
      left_valid  <= done & done_left & ~hold;
      right_valid <= done & ~done_left & ~hold;
      if (done && !hold) begin
        if (done_left) left_data  <= word;
        else           right_data <= word;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx import sar_pkg::*; #(
  parameter int WORD_W      = 24,
  parameter int HALF_SLOTS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [1:0]        wlen,
  input  logic              sclk_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic [WORD_W-1:0] left_data,
  output logic              left_valid,
  output logic [WORD_W-1:0] right_data,
  output logic              right_valid
);

  logic [2:0]        lines;
  logic              bit_tick, fmt_change, done, done_left;
  logic [1:0]        mode_q, wlen_q;
  logic [WORD_W-1:0] word;

  sar_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   ({sd_in, ws_in, sclk_in}),
    .dout  (lines),
    .rise0 (bit_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode;
      wlen_q <= wlen;
    end else begin
      mode_q <= mode;
      wlen_q <= wlen;
    end
  end

  assign fmt_change = (mode != mode_q) || (wlen != wlen_q);

  sar_framer #(.WORD_W(WORD_W), .HALF_SLOTS(HALF_SLOTS)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .ws         (lines[1]),
    .sd         (lines[2]),
    .fmt        (fmt_e'(mode)),
    .wlen       (wlen),
    .fmt_change (fmt_change),
    .done       (done),
    .done_left  (done_left),
    .word       (word)
  );

  sar_steer #(.WORD_W(WORD_W)) u_steer (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .done_left   (done_left),
    .hold        (fmt_change),
    .word        (word),
    .left_data   (left_data),
    .left_valid  (left_valid),
    .right_data  (right_data),
    .right_valid (right_valid)
  );

endmodule

// File: rtl/sar_chk.sv
module sar_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [WORD_W-1:0] left_data,
  input logic              left_valid,
  input logic [WORD_W-1:0] right_data,
  input logic              right_valid
);

  // R8
  left_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    left_valid |=> !left_valid);

  // R8
  right_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    right_valid |=> !right_valid);

  // R8
  no_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(left_valid && right_valid));

  // R1
  left_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !left_valid |-> $stable(left_data));

  // R1
  right_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !right_valid |-> $stable(right_data));

  // R9
  fmt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |=> (!left_valid && !right_valid));

endmodule

bind serial_audio_rx sar_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode        (mode),
  .left_data   (left_data),
  .left_valid  (left_valid),
  .right_data  (right_data),
  .right_valid (right_valid)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b01;
  logic [1:0]  wlen = 2'b00;
  logic        sclk_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
  logic [23:0] left_data, right_data;
  logic        left_valid, right_valid;

  always #10 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rst(rst), .mode(mode), .wlen(wlen),
    .sclk_in(sclk_in), .ws_in(ws_in), .sd_in(sd_in),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid)
  );

  int checks = 0, failures = 0, cyc = 0, mark_cyc = 0;
  int nl = 0, nr = 0;
  logic [23:0] lbuf [256];
  logic [23:0] rbuf [256];
  int          lcyc [256];
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (left_valid)  begin lbuf[nl % 256] = left_data;  lcyc[nl % 256] = cyc; nl = nl + 1; end
    if (right_valid) begin rbuf[nr % 256] = right_data; nr = nr + 1; end
  end

  // {mode, wlen, nbits, left, right}
  localparam int NV = 12;
  localparam logic [57:0] VEC [NV] = '{
    {2'b01, 2'b00, 6'd24, 24'h123456, 24'hFEDCBA},
    {2'b01, 2'b00, 6'd16, 24'hA5C37E, 24'h80FF11},
    {2'b01, 2'b00, 6'd28, 24'h7ABCDE, 24'h811111},
    {2'b00, 2'b00, 6'd24, 24'h89ABCD, 24'h13579B},
    {2'b00, 2'b00, 6'd20, 24'hC0FFEE, 24'h0F0F0F},
    {2'b00, 2'b00, 6'd30, 24'h2468AC, 24'hFDB975},
    {2'b10, 2'b00, 6'd24, 24'h800001, 24'h7FFFFE},
    {2'b10, 2'b01, 6'd20, 24'h081234, 24'h012345},
    {2'b10, 2'b10, 6'd16, 24'h008001, 24'h007FFF},
    {2'b10, 2'b11, 6'd24, 24'hABCDEF, 24'h000001},
    {2'b11, 2'b00, 6'd24, 24'h5A5A5A, 24'hA5A5A5},
    {2'b11, 2'b00, 6'd16, 24'h1234FF, 24'hFEDC77}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic w, input logic d, input bit mark);
    @(negedge clk);
    sclk_in = 1'b0; ws_in = w; sd_in = d;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    if (mark) mark_cyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_fmt(input logic [1:0] m, input logic [1:0] w);
    repeat (2) @(negedge clk);
    mode = m ^ 2'b01;
    @(negedge clk);
    mode = m; wlen = w;
    repeat (2) @(negedge clk);
  endtask

  function automatic int rj_bits(input logic [1:0] w);
    return (w == 2'b01) ? 20 : (w == 2'b10) ? 16 : 24;
  endfunction

  task automatic send_frame(input logic [1:0] m, input logic [1:0] w, input int nb,
                            input logic [23:0] lv, input logic [23:0] rv, input bit mk);
    if (m == 2'b11) begin
      for (int b = 0; b < 64; b++) begin
        logic d;
        d = 1'b0;
        if (b >= 1 && b <= 24 && (b - 1) < nb)  d = lv[24 - b];
        if (b >= 25 && b <= 48 && (b - 25) < nb) d = rv[48 - b];
        bit_out(b == 0, d, mk && b == 24);
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        logic [23:0] v;
        logic        wsv;
        int          len, off;
        v   = (h == 0) ? lv : rv;
        wsv = (m == 2'b00) ? (h == 1) : (h == 0);
        len = rj_bits(w);
        off = 32 - len;
        for (int s = 0; s < 32; s++) begin
          logic d;
          int   p;
          p = (m == 2'b00) ? s - 1 : s;
          if (m == 2'b10)      d = (s < off) ? 1'b1 : v[len - 1 - (s - off)];
          else if (p < 0)      d = 1'b1;
          else if (p >= nb)    d = 1'b0;
          else if (p >= 24)    d = 1'b1;
          else                 d = v[23 - p];
          bit_out(wsv, d, mk && h == 1 && s == 0);
        end
      end
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [1:0] m, input logic [1:0] w,
                                              input int nb, input logic [23:0] v);
    logic [23:0] r;
    int len;
    if (m == 2'b10) begin
      len = rj_bits(w);
      for (int i = 0; i < 24; i++) r[i] = (i < len) ? v[i] : v[len - 1];
    end else begin
      r = v;
      for (int i = 0; i < 24; i++) if (i < 24 - nb) r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic string tag_for(input logic [1:0] m, input int nb);
    if (m != 2'b10 && nb < 24) return "R6";
    if (m != 2'b10 && m != 2'b11 && nb > 24) return "R7";
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R2";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(left_data == 24'd0 && right_data == 24'd0, "R1", {8'd0, left_data}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(left_data == 24'd0, "R1", {8'd0, left_data}, 0);
    chk(right_data == 24'd0, "R1", {8'd0, right_data}, 0);
    chk(nl == 0 && nr == 0, "R1", nl + nr, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  m, w;
      int          nb, bl, br;
      logic [23:0] lv, rv, el, er;
      string       t;
      m  = VEC[i][57:56]; w = VEC[i][55:54]; nb = int'(VEC[i][53:48]);
      lv = VEC[i][47:24]; rv = VEC[i][23:0];
      el = expect_word(m, w, nb, lv);
      er = expect_word(m, w, nb, rv);
      t  = tag_for(m, nb);
      bit_out((m == 2'b00), 1'b0, 1'b0);
      set_fmt(m, w);
      bl = nl; br = nr;
      send_frame(m, w, nb, lv, rv, 1'b1);
      send_frame(m, w, nb, 24'd0, 24'd0, 1'b0);
      repeat (8) @(negedge clk);
      chk(nl > bl && lbuf[bl % 256] == el, t, {8'd0, lbuf[bl % 256]}, {8'd0, el});
      chk(nr > br && rbuf[br % 256] == er, t, {8'd0, rbuf[br % 256]}, {8'd0, er});
      // R8: strobe latency from the closing bit-clock rise
      chk(lcyc[bl % 256] - mark_cyc == 4, "R8", lcyc[bl % 256] - mark_cyc, 4);
    end

    // R9: frame-sync mode, no rising word clock -> nothing emitted
    bit_out(1'b0, 1'b0, 1'b0);
    set_fmt(2'b11, 2'b00);
    begin
      int bl, br;
      bl = nl; br = nr;
      for (int b = 0; b < 40; b++) bit_out(1'b0, 1'b1, 1'b0);
      repeat (8) @(negedge clk);
      chk(nl == bl && nr == br, "R9", (nl - bl) + (nr - br), 0);
    end

    // R9: format change in the middle of a left word
    bit_out(1'b0, 1'b0, 1'b0);
    set_fmt(2'b01, 2'b00);
    begin
      int bl;
      bl = nl;
      for (int s = 0; s < 12; s++) bit_out(1'b1, 1'b1, 1'b0);
      set_fmt(2'b01, 2'b00);
      for (int s = 0; s < 32; s++) bit_out(1'b0, 1'b0, 1'b0);
      send_frame(2'b01, 2'b00, 24, 24'h3C3C3C, 24'h111111, 1'b0);
      repeat (8) @(negedge clk);
      chk(nl - bl == 1, "R9", nl - bl, 1);
      chk(lbuf[bl % 256] == 24'h3C3C3C, "R9", {8'd0, lbuf[bl % 256]}, 32'h3C3C3C);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule